// File: doc/BRIEF.md
# Interrupt Mask and Source Unit

This block gathers the interrupt causes of a USB peripheral controller into one request line for the on-chip microcontroller. It holds two byte-wide registers behind a plain register port. The first is an enable-inverted mask covering eight level requests: four external interrupt pins, plus four events from the buffer manager and the DMA engine. The second is a sticky source register that latches five serial-engine events. Firmware clears each of those bits by writing a one to it.

Each source bit has its own qualifying rule:
- The transaction-end bit fires when the engine drops from busy to idle.
- The frame bit fires on a frame-count write strobe, but only after a good frame token has armed it.
- The allocation bit ignores completions that were issued by hardware DMA.
- The wake bit fires on the rising edge of a wake level.

The single interrupt output is registered. It combines the enabled level requests with every latched source bit. The mask register does not gate the source bits.

The register port has no handshake. A write takes effect on the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`. No streaming interface is present.

Top module: `irq_mask_src_unit`

## Requirements
- R1: After reset the mask register reads 0xFF, the source register reads 0x00, and `irq_out` is 0.
- R2: The mask register (address 0) is read/write. A 0 in mask bit i lets level request i drive `irq_out`. Bits 7..4 are `ext_irq[3:0]`, and bits 3..0 are `buf_evt[3:0]` (received packet, transmit queue empty, packet transmitted, DMA status change).
- R3: A level request whose mask bit is 1 does not raise `irq_out`.
- R4: The source register (address 1) clears a bit when a 1 is written to it. Writing 0 leaves the bit unchanged. Bits 7..5 always read 0, and writes to them are ignored. Unused addresses read 0.
- R5: Source bit 4 sets when `eng_busy` is 1 on one clock edge and 0 on the next.
- R6: Source bit 3 sets on a `frame_cnt_wr` strobe only if a `sof_tok_ok` strobe came earlier. Each token arms exactly one strobe, and a strobe with no token has no effect.
- R7: Source bit 2 sets when `alloc_done` is high with `alloc_by_hw` low. A completion with `alloc_by_hw` high is ignored.
- R8: Source bit 1 sets on a `rx_overrun` strobe. Source bit 0 sets on a rising edge of `wake_lvl`, and a level that stays high does not set it again after a clear.
- R9: When an event and a write-one-to-clear reach the same source bit in the same cycle, the bit ends up set.
- R10: `irq_out` is registered and changes one cycle after the state that drives it. Any latched source bit raises it, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 = mask, 1 = source |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ext_irq | input | 4 | External interrupt levels |
| buf_evt | input | 4 | Buffer-manager / DMA levels: [3] rx packet, [2] tx empty, [1] tx packet, [0] DMA change |
| eng_busy | input | 1 | Serial engine is out of idle |
| sof_tok_ok | input | 1 | Strobe: a frame token was decoded without error |
| frame_cnt_wr | input | 1 | Strobe: the frame-count register is being written |
| alloc_done | input | 1 | Strobe: an allocation request completed |
| alloc_by_hw | input | 1 | The completed allocation was issued by hardware DMA |
| rx_overrun | input | 1 | Strobe: receive overrun |
| wake_lvl | input | 1 | Combined wake / power-management level |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
The assertions check several rules on every cycle:
- A latched source bit always raises the output one cycle later.
- With everything masked and nothing latched, the output stays low.
- A receive overrun survives a simultaneous clear.
- A write-one-to-clear on the overrun bit takes effect when no event competes with it.
- The frame and allocation bits only rise after their qualifying strobe.
- The reserved bits always read zero.

Some behaviours can only be shown by the bench's scenarios:
- The per-bit mask mapping.
- The busy-to-idle edge rule and the rule that one token arms one strobe.
- The hardware-allocation filter.
- A wake level that stays high and does not re-trigger.
- The exact one-cycle delay of the registered output.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int DATA_W = 8;
  localparam int N_EXT  = 4;
  localparam int N_BUF  = 4;
  localparam int MASK_W = N_EXT + N_BUF;
  localparam int N_SRC  = 5;
  localparam logic [MASK_W-1:0] MASK_RST = '1;

  // source bit positions (firmware decodes these)
  localparam int SB_WAKE  = 0;
  localparam int SB_OVRN  = 1;
  localparam int SB_ALLOC = 2;
  localparam int SB_SOF   = 3;
  localparam int SB_EOT   = 4;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= RST_VAL;
    else if (wr_en) mask_q <= wdata;
  end
endmodule

// File: rtl/irq_evt_qualify.sv
module irq_evt_qualify
  import irq_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_busy,
  input  logic             sof_tok_ok,
  input  logic             frame_cnt_wr,
  input  logic             alloc_done,
  input  logic             alloc_by_hw,
  input  logic             rx_overrun,
  input  logic             wake_lvl,
  output logic [N_SRC-1:0] set_vec
);
  logic busy_d, wake_d, sof_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_d    <= 1'b0;
      wake_d    <= 1'b0;
      sof_armed <= 1'b0;
    end else begin
      busy_d <= eng_busy;
      wake_d <= wake_lvl;
      if (sof_tok_ok)        sof_armed <= 1'b1;
      else if (frame_cnt_wr) sof_armed <= 1'b0;
    end
  end

  always_comb begin
    set_vec           = '0;
    set_vec[SB_EOT]   = busy_d & ~eng_busy;
    set_vec[SB_SOF]   = frame_cnt_wr & sof_armed;
    set_vec[SB_ALLOC] = alloc_done & ~alloc_by_hw;
    set_vec[SB_OVRN]  = rx_overrun;
    set_vec[SB_WAKE]  = wake_lvl & ~wake_d;
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] src_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          src_q[i] <= 1'b0;
      else if (set_vec[i]) src_q[i] <= 1'b1;  // event beats clear
      else if (clr_vec[i]) src_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int MW = 8,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] req,
  input  logic [MW-1:0] mask,
  input  logic [SW-1:0] src,
  output logic          irq_q
);
  logic any_req;
  assign any_req = (|(req & ~mask)) | (|src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_req;
  end
endmodule

// File: rtl/irq_mask_src_unit.sv
module irq_mask_src_unit
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int MASK_ADR = 0,
  parameter int SRC_ADR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_BUF-1:0]  buf_evt,
  input  logic              eng_busy,
  input  logic              sof_tok_ok,
  input  logic              frame_cnt_wr,
  input  logic              alloc_done,
  input  logic              alloc_by_hw,
  input  logic              rx_overrun,
  input  logic              wake_lvl,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADR);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(SRC_ADR);

  logic              sel_mask, sel_src;
  logic [MASK_W-1:0] mask_q, req_vec;
  logic [N_SRC-1:0]  src_q, set_vec, clr_vec;

  assign sel_mask = (reg_addr == A_MASK);
  assign sel_src  = (reg_addr == A_SRC);
  assign req_vec  = {ext_irq, buf_evt};
  assign clr_vec  = (reg_wr && sel_src) ? reg_wdata[N_SRC-1:0] : '0;

  irq_mask_bank #(.W(MASK_W), .RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel_mask),
    .wdata(reg_wdata[MASK_W-1:0]), .mask_q(mask_q)
  );

  irq_evt_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .sof_tok_ok(sof_tok_ok),
    .frame_cnt_wr(frame_cnt_wr), .alloc_done(alloc_done),
    .alloc_by_hw(alloc_by_hw), .rx_overrun(rx_overrun),
    .wake_lvl(wake_lvl), .set_vec(set_vec)
  );

  irq_src_bank #(.N(N_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .src_q(src_q)
  );

  irq_combine #(.MW(MASK_W), .SW(N_SRC)) u_comb (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .mask(mask_q), .src(src_q),
    .irq_q(irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_mask)     reg_rdata[MASK_W-1:0] = mask_q;
    else if (sel_src) reg_rdata[N_SRC-1:0]  = src_q;
  end
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
  parameter int ADDR_W  = 2,
  parameter int SRC_ADR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wd_ovrn,
  input logic [2:0]        rd_resv,
  input logic              alloc_done,
  input logic              alloc_by_hw,
  input logic              frame_cnt_wr,
  input logic              rx_overrun,
  input logic [7:0]        mask_q,
  input logic [4:0]        src_q,
  input logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_SRC = ADDR_W'(SRC_ADR);

  // R3
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'hFF && src_q == 5'd0) |=> !irq_out);
  // R10
  src_drives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_q) |=> irq_out);
  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> src_q[1]);
  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SRC && wd_ovrn && !rx_overrun) |=> !src_q[1]);
  // R7
  alloc_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_q[2]) |-> $past(alloc_done && !alloc_by_hw));
  // R6
  sof_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_q[3]) |-> $past(frame_cnt_wr));
  // R4
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_SRC) |-> (rd_resv == 3'd0));
endmodule

bind irq_mask_src_unit irq_unit_chk #(.ADDR_W(ADDR_W), .SRC_ADR(SRC_ADR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wd_ovrn(reg_wdata[1]), .rd_resv(reg_rdata[7:5]),
  .alloc_done(alloc_done), .alloc_by_hw(alloc_by_hw),
  .frame_cnt_wr(frame_cnt_wr), .rx_overrun(rx_overrun),
  .mask_q(mask_q), .src_q(src_q), .irq_out(irq_out)
);

// File: tb/sim_irq_mask_src_unit.sv
`timescale 1ns/1ps
module sim_irq_mask_src_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [3:0] ext_irq = 4'd0;
  logic [3:0] buf_evt = 4'd0;
  logic eng_busy = 1'b0, sof_tok_ok = 1'b0, frame_cnt_wr = 1'b0;
  logic alloc_done = 1'b0, alloc_by_hw = 1'b0, rx_overrun = 1'b0, wake_lvl = 1'b0;
  logic irq_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #2.5 clk = ~clk;

  irq_mask_src_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_irq(ext_irq),
    .buf_evt(buf_evt), .eng_busy(eng_busy), .sof_tok_ok(sof_tok_ok),
    .frame_cnt_wr(frame_cnt_wr), .alloc_done(alloc_done),
    .alloc_by_hw(alloc_by_hw), .rx_overrun(rx_overrun),
    .wake_lvl(wake_lvl), .irq_out(irq_out)
  );

  // monitor: compares at the falling edge, away from driver activity
  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      checks++;
      if (it.is_irq) begin
        if (irq_out !== it.exp[0]) begin
          errors++;
          $display("FAIL %s irq_out actual %b expected %b", it.tag, irq_out, it.exp[0]);
        end
      end else if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic check_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    sbq.push_back('{1'b0, e, tag});
    step();
  endtask

  // waits one cycle for the registered output, then checks it
  task automatic check_irq(input logic e, input string tag);
    step();
    sbq.push_back('{1'b1, {7'd0, e}, tag});
    step();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    sbq.push_back('{1'b1, 8'd0, "R1 irq in reset"});
    step();
    rst_n = 1'b1;
    step();
    check_rd(2'd0, 8'hFF, "R1 mask reset");
    check_rd(2'd1, 8'h00, "R1 source reset");
    check_irq(1'b0, "R1 irq after reset");
    check_rd(2'd2, 8'h00, "R4 unused address");

    // R2 / R3 mask mapping
    wr(2'd0, 8'h00);
    check_rd(2'd0, 8'h00, "R2 mask readback");
    check_irq(1'b0, "R2 no request");
    buf_evt[2] = 1'b1;
    check_irq(1'b1, "R2 tx empty enabled");
    wr(2'd0, 8'h04);
    check_irq(1'b0, "R3 tx empty masked by bit 2");
    buf_evt[2] = 1'b0;
    ext_irq[1] = 1'b1;
    wr(2'd0, 8'hDF);
    check_irq(1'b1, "R2 ext1 enabled by bit 5");
    wr(2'd0, 8'hEF);
    check_irq(1'b0, "R3 ext1 masked with only bit 4 clear");
    wr(2'd0, 8'hFF);
    ext_irq[1] = 1'b0;
    wr(2'd0, 8'hA5);
    check_rd(2'd0, 8'hA5, "R2 mask pattern");
    wr(2'd0, 8'hFF);

    // R8 overrun, R10 timing, R4 clear
    rx_overrun = 1'b1; step(); rx_overrun = 1'b0;
    sbq.push_back('{1'b1, 8'd0, "R10 irq one cycle late"});
    check_rd(2'd1, 8'h02, "R8 overrun latched");
    check_irq(1'b1, "R10 source ignores mask");
    wr(2'd1, 8'h00);
    check_rd(2'd1, 8'h02, "R4 zero write keeps bit");
    wr(2'd1, 8'hE2);
    check_rd(2'd1, 8'h00, "R4 one write clears");
    check_irq(1'b0, "R4 irq drops after clear");

    // R5 transaction end
    eng_busy = 1'b1; step(); step();
    check_rd(2'd1, 8'h00, "R5 busy alone no set");
    eng_busy = 1'b0; step();
    check_rd(2'd1, 8'h10, "R5 busy to idle");
    wr(2'd1, 8'h10);

    // R6 frame
    frame_cnt_wr = 1'b1; step(); frame_cnt_wr = 1'b0;
    check_rd(2'd1, 8'h00, "R6 strobe without token");
    sof_tok_ok = 1'b1; step(); sof_tok_ok = 1'b0;
    frame_cnt_wr = 1'b1; step(); frame_cnt_wr = 1'b0;
    check_rd(2'd1, 8'h08, "R6 armed strobe");
    wr(2'd1, 8'h08);
    frame_cnt_wr = 1'b1; step(); frame_cnt_wr = 1'b0;
    check_rd(2'd1, 8'h00, "R6 token used once");

    // R7 allocation
    alloc_done = 1'b1; alloc_by_hw = 1'b1; step(); alloc_done = 1'b0; alloc_by_hw = 1'b0;
    check_rd(2'd1, 8'h00, "R7 hardware alloc ignored");
    alloc_done = 1'b1; step(); alloc_done = 1'b0;
    check_rd(2'd1, 8'h04, "R7 software alloc");
    wr(2'd1, 8'h04);

    // R8 wake
    wake_lvl = 1'b1; step();
    check_rd(2'd1, 8'h01, "R8 wake rising");
    wr(2'd1, 8'h01);
    step();
    check_rd(2'd1, 8'h00, "R8 held wake no retrigger");
    wake_lvl = 1'b0;

    // R9 set wins
    rx_overrun = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h02;
    step();
    rx_overrun = 1'b0; reg_wr = 1'b0;
    check_rd(2'd1, 8'h02, "R9 set beats clear");
    wr(2'd1, 8'h02);
    wr(2'd1, 8'hE0);
    check_rd(2'd1, 8'h00, "R4 reserved write no effect");
    check_irq(1'b0, "R10 idle at end");

    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule